// File: doc/BRIEF.md
# Indirect Configuration Register Window with Keyed Soft Reset

This block is the register-access front end of a serial bus controller. Software sees only two byte-wide locations. One is an index pointer and the other is a data window. The pointer value chooses which entry of an internal configuration bank the window reaches. The bank holds five registers, each driven out to the serial engine:

- the controller's own bus address,
- a timeout count,
- a mode byte whose top bit is the bus enable,
- the clock-low period count,
- the clock-high period count.

A reserved index holds no storage. It acts as a lock for a soft reset of the controller. Software points at that index and writes a fixed pair of key bytes through the window. The block then raises a single-cycle reset pulse. On the edge that ends the pulse, every bank register returns to its default. Software must then write the mode, both clock period counts and the enable bit again before the bus can be used.

The bus interface has no handshake. A write is accepted on any rising clock edge where `bus_wr` is high. Reads are combinational: `bus_rdata` follows `bus_sel` and the pointer in the same cycle.

Top module: `cfg_window_port`

## Requirements
- R1: A write with `bus_sel`=0 loads the index pointer. With `bus_sel`=0, `bus_rdata` returns the pointer. With `bus_sel`=1, `bus_rdata` returns the bank entry that the pointer selects.
- R2: A write with `bus_sel`=1 stores the data byte in the register at the pointer. The indices are own address 0x00, timeout 0x01, mode 0x02, clock-low 0x03 and clock-high 0x04. The matching output shows the new value from the clock edge that takes the write.
- R3: A value written to the own-address register reads back unchanged, and a later window write to the timeout register leaves it as it was.
- R4: A window read at any index of 0x05 or above returns 0x00. This includes the reset index 0x0F. A window write at such an index changes no register.
- R5: With the pointer at 0x0F, a window write of 0xA5 followed by a window write of 0x5A makes `soft_rst_o` high for exactly one clock cycle. The pulse starts at the edge that takes the 0x5A write. The two key writes need not be in back-to-back cycles.
- R6: Any window byte at index 0x0F other than the one expected next cancels the key sequence. This includes a second 0xA5 after 0xA5. A lone 0x5A also produces no pulse.
- R7: Any pointer write between the two key bytes cancels the sequence, even if it writes 0x0F again.
- R8: On the edge that ends the reset pulse, all bank registers return to their defaults and the pointer returns to 0x00. The defaults are own address 0x00, timeout 0xFF, mode 0x00 (bus enable, bit 7, clear), clock-low 0x9D and clock-high 0x86. Any bus write taken on that edge is ignored.
- R9: While `rst_n` is low, the registers hold their defaults, the pointer is 0x00 and `soft_rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the pointer port, 1 selects the data window |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| own_addr_o | output | 8 | Own bus address register |
| timeout_o | output | 8 | Timeout count register |
| mode_o | output | 8 | Mode register, bit 7 is the bus enable |
| scl_lo_o | output | 8 | Clock-low period count register |
| scl_hi_o | output | 8 | Clock-high period count register |
| soft_rst_o | output | 1 | One-cycle soft reset pulse to the controller |

## Verification
`bus_rdata` is combinational, so a read is due in the same cycle that `bus_sel` changes. Register outputs and the pointer change one rising edge after a write. `soft_rst_o` rises one edge after the second key byte, and the defaults appear one edge after that. The bench drives every input on the falling edge and samples one falling edge later, half a period after each edge that matters. The sampling point is therefore fixed relative to each edge. Key checks sample `soft_rst_o` on both the cycle the pulse is due and the cycle after, so a pulse that comes late or lasts too long is caught as well as a missing one.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

   // State of the two-byte unlock sequence
   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;

   // Port select encoding on the byte bus
   localparam logic SEL_PTR = 1'b0;
   localparam logic SEL_WIN = 1'b1;

   // Number of bank registers that have a named output
   localparam int NAMED_REGS = 5;

endpackage

// File: rtl/cfgw_ptr_reg.sv
module cfgw_ptr_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              ptr_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ptr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (soft_clr)
         ptr_q <= '0;
      else if (ptr_wr)
         ptr_q <= wdata;
   end

endmodule

// File: rtl/cfgw_key_detect.sv
module cfgw_key_detect
   import cfgw_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] RST_IDX    = 8'h0F,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_wr,
   input  logic              ptr_wr,
   input  logic [DATA_W-1:0] ptr_q,
   input  logic [DATA_W-1:0] wdata,
   output logic              soft_rst_q
);

   key_state_e state_q, state_d;
   logic       at_key_idx;
   logic       fire;

   assign at_key_idx = win_wr && (ptr_q == RST_IDX);
   assign fire       = at_key_idx && (state_q == KEY_ARMED) &&
                       (wdata == KEY_SECOND) && !soft_rst_q;

   always_comb begin
      state_d = state_q;
      if (soft_rst_q || ptr_wr) begin
         state_d = KEY_IDLE;
      end else if (at_key_idx) begin
         if ((state_q == KEY_IDLE) && (wdata == KEY_FIRST))
            state_d = KEY_ARMED;
         else
            state_d = KEY_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= KEY_IDLE;
         soft_rst_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         soft_rst_q <= fire;
      end
   end

endmodule

// File: rtl/cfgw_reg_bank.sv
module cfgw_reg_bank #(
   parameter int                          DATA_W   = 8,
   parameter int                          NUM_REGS = 5,
   parameter logic [NUM_REGS*DATA_W-1:0]  DEFAULTS = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       soft_clr,
   input  logic                       win_wr,
   input  logic [DATA_W-1:0]          ptr_q,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [DATA_W-1:0] MY_IDX = DATA_W'(gi);
      localparam logic [DATA_W-1:0] MY_DEF = DEFAULTS[gi*DATA_W +: DATA_W];
      logic sel_me;
      assign sel_me = win_wr && (ptr_q == MY_IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_flat[gi*DATA_W +: DATA_W] <= MY_DEF;
         else if (soft_clr)
            regs_flat[gi*DATA_W +: DATA_W] <= MY_DEF;
         else if (sel_me)
            regs_flat[gi*DATA_W +: DATA_W] <= wdata;
      end
   end

endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
   import cfgw_pkg::*;
#(
   parameter int                 DATA_W     = 8,
   parameter int                 NUM_REGS   = 5,
   parameter logic [DATA_W-1:0]  RST_IDX    = 8'h0F,
   parameter logic [DATA_W-1:0]  KEY_FIRST  = 8'hA5,
   parameter logic [DATA_W-1:0]  KEY_SECOND = 8'h5A,
   parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS =
      {8'h86, 8'h9D, 8'h00, 8'hFF, 8'h00}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] own_addr_o,
   output logic [DATA_W-1:0] timeout_o,
   output logic [DATA_W-1:0] mode_o,
   output logic [DATA_W-1:0] scl_lo_o,
   output logic [DATA_W-1:0] scl_hi_o,
   output logic              soft_rst_o
);

   localparam logic [DATA_W-1:0] BANK_TOP = DATA_W'(NUM_REGS);

   // Elaboration-time parameter checks
   if (NUM_REGS < NAMED_REGS) begin : g_bad_depth
      $error("cfg_window_port: NUM_REGS must be at least %0d", NAMED_REGS);
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("cfg_window_port: DATA_W too narrow");
   end
   if (RST_IDX < BANK_TOP) begin : g_bad_idx
      $error("cfg_window_port: RST_IDX overlaps the register bank");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_bad_key
      $error("cfg_window_port: key bytes must differ");
   end

   logic                       win_wr;
   logic                       ptr_wr;
   logic [DATA_W-1:0]          ptr_q;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;
   logic                       soft_clr;

   assign win_wr   = bus_wr && (bus_sel == SEL_WIN);
   assign ptr_wr   = bus_wr && (bus_sel == SEL_PTR);
   assign soft_clr = soft_rst_o;

   cfgw_ptr_reg #(
      .DATA_W (DATA_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .ptr_wr   (ptr_wr),
      .wdata    (bus_wdata),
      .ptr_q    (ptr_q)
   );

   cfgw_key_detect #(
      .DATA_W     (DATA_W),
      .RST_IDX    (RST_IDX),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_key (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_wr     (win_wr),
      .ptr_wr     (ptr_wr),
      .ptr_q      (ptr_q),
      .wdata      (bus_wdata),
      .soft_rst_q (soft_rst_o)
   );

   cfgw_reg_bank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .DEFAULTS (DEFAULTS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .win_wr    (win_wr),
      .ptr_q     (ptr_q),
      .wdata     (bus_wdata),
      .regs_flat (regs_flat)
   );

   // Named outputs
   assign own_addr_o = regs_flat[0*DATA_W +: DATA_W];
   assign timeout_o  = regs_flat[1*DATA_W +: DATA_W];
   assign mode_o     = regs_flat[2*DATA_W +: DATA_W];
   assign scl_lo_o   = regs_flat[3*DATA_W +: DATA_W];
   assign scl_hi_o   = regs_flat[4*DATA_W +: DATA_W];

   // Read path: pointer, or the selected bank entry (zero outside the bank)
   always_comb begin
      bus_rdata = '0;
      if (bus_sel == SEL_PTR) begin
         bus_rdata = ptr_q;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr_q == DATA_W'(i))
               bus_rdata = regs_flat[i*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/cfg_window_port_chk.sv
module cfg_window_port_chk #(
   parameter int                 DATA_W     = 8,
   parameter int                 NUM_REGS   = 5,
   parameter logic [DATA_W-1:0]  RST_IDX    = 8'h0F,
   parameter logic [DATA_W-1:0]  KEY_SECOND = 8'h5A,
   parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] own_addr_o,
   input logic [DATA_W-1:0] timeout_o,
   input logic [DATA_W-1:0] mode_o,
   input logic [DATA_W-1:0] scl_lo_o,
   input logic [DATA_W-1:0] scl_hi_o,
   input logic              soft_rst_o,
   input logic [DATA_W-1:0] ptr_q
);

   localparam logic [DATA_W-1:0] BANK_TOP = DATA_W'(NUM_REGS);
   localparam logic [DATA_W-1:0] IDX_OWN  = DATA_W'(0);
   localparam logic [DATA_W-1:0] IDX_TOUT = DATA_W'(1);

   // R2
   own_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel && ptr_q == IDX_OWN && !soft_rst_o)
      |=> (own_addr_o == $past(bus_wdata)));

   // R3
   own_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel && ptr_q == IDX_TOUT && !soft_rst_o)
      |=> $stable(own_addr_o));

   // R4
   unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && ptr_q >= BANK_TOP) |-> (bus_rdata == '0));

   // R4
   unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel && ptr_q >= BANK_TOP && !soft_rst_o)
      |=> ($stable(own_addr_o) && $stable(timeout_o) && $stable(mode_o) &&
           $stable(scl_lo_o) && $stable(scl_hi_o)));

   // R5
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);

   // R5
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> $past(bus_wr && bus_sel && ptr_q == RST_IDX &&
                           bus_wdata == KEY_SECOND));

   // R8
   defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> (own_addr_o == DEFAULTS[0*DATA_W +: DATA_W] &&
                      timeout_o  == DEFAULTS[1*DATA_W +: DATA_W] &&
                      mode_o     == DEFAULTS[2*DATA_W +: DATA_W] &&
                      scl_lo_o   == DEFAULTS[3*DATA_W +: DATA_W] &&
                      scl_hi_o   == DEFAULTS[4*DATA_W +: DATA_W] &&
                      ptr_q      == '0));

endmodule

bind cfg_window_port cfg_window_port_chk #(
   .DATA_W     (DATA_W),
   .NUM_REGS   (NUM_REGS),
   .RST_IDX    (RST_IDX),
   .KEY_SECOND (KEY_SECOND),
   .DEFAULTS   (DEFAULTS)
) u_chk (.*);

// File: tb/cfg_window_port_bench.sv
module cfg_window_port_bench;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] own_addr_o, timeout_o, mode_o, scl_lo_o, scl_hi_o;
   logic       soft_rst_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   cfg_window_port u_cfg_window_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .own_addr_o (own_addr_o),
      .timeout_o  (timeout_o),
      .mode_o     (mode_o),
      .scl_lo_o   (scl_lo_o),
      .scl_hi_o   (scl_hi_o),
      .soft_rst_o (soft_rst_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Write starting at the current falling edge
   task automatic wr_now(input logic sel, input logic [7:0] d);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_now(sel, d);
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      bus_sel = sel;
      #1 v = bus_rdata;
   endtask

   task automatic check_defaults(input string req);
      logic [7:0] v;
      chk(req, own_addr_o, 8'h00);
      chk(req, timeout_o,  8'hFF);
      chk(req, mode_o,     8'h00);
      chk(req, scl_lo_o,   8'h9D);
      chk(req, scl_hi_o,   8'h86);
      rd(1'b0, v);
      chk(req, v, 8'h00);
   endtask

   task automatic t_reset();
      check_defaults("R9 reset");
      chk("R9 pulse", {7'd0, soft_rst_o}, 8'h00);
   endtask

   task automatic t_pointer();
      logic [7:0] v;
      wr(1'b0, 8'h03);
      rd(1'b0, v); chk("R1 ptr readback", v, 8'h03);
      rd(1'b1, v); chk("R1 window select", v, 8'h9D);
   endtask

   task automatic t_write_regs();
      logic [7:0] v;
      for (int i = 0; i < 5; i++) begin
         wr(1'b0, 8'(i));
         wr(1'b1, 8'(8'h30 + i * 8'h11));
         rd(1'b1, v);
         chk("R2 window readback", v, 8'(8'h30 + i * 8'h11));
      end
      chk("R2 own", own_addr_o, 8'h30);
      chk("R2 timeout", timeout_o, 8'h41);
      chk("R2 mode", mode_o, 8'h52);
      chk("R2 scl_lo", scl_lo_o, 8'h63);
      chk("R2 scl_hi", scl_hi_o, 8'h74);
   endtask

   task automatic t_own_timeout();
      logic [7:0] v;
      wr(1'b0, 8'h00); wr(1'b1, 8'h42);
      wr(1'b0, 8'h01); wr(1'b1, 8'h37);
      wr(1'b0, 8'h00);
      rd(1'b1, v);
      chk("R3 own readback", v, 8'h42);
      chk("R3 own output", own_addr_o, 8'h42);
      chk("R3 timeout", timeout_o, 8'h37);
   endtask

   task automatic t_unimpl();
      logic [7:0] v;
      logic [39:0] snap;
      snap = {own_addr_o, timeout_o, mode_o, scl_lo_o, scl_hi_o};
      wr(1'b0, 8'h09); wr(1'b1, 8'hEE);
      rd(1'b1, v); chk("R4 unimpl read", v, 8'h00);
      wr(1'b0, 8'h0F); wr(1'b1, 8'h33);
      rd(1'b1, v); chk("R4 reset idx read", v, 8'h00);
      n_chk++;
      if ({own_addr_o, timeout_o, mode_o, scl_lo_o, scl_hi_o} !== snap) begin
         n_bad++;
         $display("FAIL R4 regs disturbed: actual %010h expected %010h",
                  {own_addr_o, timeout_o, mode_o, scl_lo_o, scl_hi_o}, snap);
      end
   endtask

   task automatic t_key_ok();
      wr(1'b0, 8'h02); wr(1'b1, 8'h83);
      wr(1'b0, 8'h03); wr(1'b1, 8'h20);
      wr(1'b0, 8'h04); wr(1'b1, 8'h10);
      wr(1'b0, 8'h0F);
      wr(1'b1, 8'hA5);
      chk("R5 no pulse after first key", {7'd0, soft_rst_o}, 8'h00);
      wr(1'b1, 8'h5A);
      chk("R5 pulse due", {7'd0, soft_rst_o}, 8'h01);
      @(negedge clk);
      chk("R5 pulse one cycle", {7'd0, soft_rst_o}, 8'h00);
      check_defaults("R8 defaults");
   endtask

   task automatic key_expect_none(input string req, input logic [7:0] b0,
                                  input logic [7:0] b1, input logic [7:0] b2);
      wr(1'b0, 8'h0F);
      wr(1'b1, b0); wr(1'b1, b1); wr(1'b1, b2);
      chk(req, {7'd0, soft_rst_o}, 8'h00);
      @(negedge clk);
      chk(req, {7'd0, soft_rst_o}, 8'h00);
   endtask

   task automatic t_key_bad();
      key_expect_none("R6 wrong middle byte", 8'hA5, 8'h11, 8'h5A);
      key_expect_none("R6 repeated first key", 8'hA5, 8'hA5, 8'h5A);
      key_expect_none("R6 lone second key", 8'h00, 8'h00, 8'h5A);
   endtask

   task automatic t_ptr_cancel();
      wr(1'b0, 8'h0F);
      wr(1'b1, 8'hA5);
      wr(1'b0, 8'h0F);
      wr(1'b1, 8'h5A);
      chk("R7 pointer write cancels", {7'd0, soft_rst_o}, 8'h00);
      @(negedge clk);
      chk("R7 pointer write cancels", {7'd0, soft_rst_o}, 8'h00);
      wr(1'b1, 8'hA5);
      @(negedge clk);
      wr(1'b1, 8'h5A);
      chk("R5 gapped key accepted", {7'd0, soft_rst_o}, 8'h01);
      @(negedge clk);
   endtask

   task automatic t_pulse_ignore();
      logic [7:0] v;
      wr(1'b0, 8'h0F);
      wr(1'b1, 8'hA5);
      wr(1'b1, 8'h5A);
      chk("R8 pulse active", {7'd0, soft_rst_o}, 8'h01);
      wr_now(1'b0, 8'h02);
      chk("R8 pulse ended", {7'd0, soft_rst_o}, 8'h00);
      rd(1'b0, v);
      chk("R8 write during pulse ignored", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_pointer();
      t_write_regs();
      t_own_timeout();
      t_unimpl();
      t_key_ok();
      t_key_bad();
      t_ptr_cancel();
      t_pulse_ignore();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule